// File: doc/BRIEF.md
# DRAM Strobe Timing Controller for an 8-bit Multiplexed-Strobe Processor Bus

This block produces the control strobes for banks of dynamic RAM attached to an 8-bit processor that has an active-low memory request and an active-low refresh strobe. It drives one active-low row strobe per bank, one column strobe shared by all banks, and the select line of an external row/column address multiplexer. Opcode fetches, ordinary reads and writes all use the same timing. The opcode fetch, which is the shortest access, sets the pace.

Refresh uses the column-before-row method. During the processor's refresh slot the column strobe is pulsed before every row strobe falls, so each device steps its own internal refresh counter. The processor's short refresh counter is never used as an address. The bank address bits and the select enable are captured when memory request falls. Address glitches later in the cycle therefore cannot disturb a row strobe.

Everything runs on the processor clock, and every output is registered. An output shows the effect of the inputs sampled at a rising edge right after that edge.

Top module: `dram_strobe_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives every `ras_n` bit and `cas_n` high and `addr_col` low (row) after that edge, even in the middle of an access.
- R2: Outside refresh (`rfsh_n` high), when `mreq_n` is sampled low, exactly the row strobe `ras_n[bank]` of the captured bank goes low, provided the captured `mem_sel` is 1. With `mem_sel` at 0 no row strobe goes low. All row strobes are high whenever `mreq_n` is sampled high. Bank index k drives bit k.
- R3: `bank_addr` and `mem_sel` are captured at the edge where `mreq_n` is first sampled low. Changes to either one while `mreq_n` stays low have no effect on `ras_n`.
- R4: When `mreq_n` and `rfsh_n` are both sampled low, every row strobe goes low, whatever the values of `mem_sel` and `bank_addr`.
- R5: `addr_col` goes high one edge after the row strobe during an access and returns low at the edge where `mreq_n` is sampled high. It stays low whenever `rfsh_n` is sampled low.
- R6: During an access, `cas_n` goes low two edges after `mreq_n` is first sampled low and stays low until `mreq_n` is sampled high. The column strobe does not depend on `mem_sel`. The same rule serves 3-, 4- and 5-cycle accesses.
- R7: When `rfsh_n` falls, `cas_n` goes low at that edge, stays low for two edges, and then returns high even if `rfsh_n` is still low. With `mreq_n` falling one cycle after `rfsh_n`, the column strobe is therefore already low when the row strobes fall.
- R8: `cas_n` is high after any edge at which both `mreq_n` and `rfsh_n` are sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| bank_addr | input | BANK_BITS | Address bits that choose the bank |
| mem_sel | input | 1 | Decoded memory-select enable, active high |
| ras_n | output | 2**BANK_BITS | Row strobe per bank, active low |
| cas_n | output | 1 | Shared column strobe, active low |
| addr_col | output | 1 | Address multiplexer select: 0 row, 1 column |

## Verification
The bench changes `bank_addr` and `mem_sel` in the middle of an access. A design that failed to hold the captured select would switch or drop a row strobe partway through the cycle. Refresh cycles run both with the select off and with it pointing at one bank. A design that gated refresh with the select would leave banks unrefreshed, and one whose refresh pulse followed the whole refresh strobe would hold `cas_n` low past the pulse. Accesses of three, four and five cycles are run, and accesses are asked for with the select off. A column strobe that was too early, ended too late or was gated by the select would show up directly, and so would a multiplexer that left the row setting during refresh. A reset in the middle of an access is also checked.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

    // Registered outputs of the column timing block
    typedef struct packed {
        logic cas_n;
        logic addr_col;
    } col_out_t;

endpackage

// File: rtl/dram_bank_latch.sv
module dram_bank_latch #(
    parameter int BANK_BITS = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mreq_n,
    input  logic [BANK_BITS-1:0] bank_addr,
    input  logic                 mem_sel,
    output logic [BANK_BITS-1:0] eff_bank,
    output logic                 eff_sel
);

    typedef struct packed {
        logic                 mreq_prev_n;
        logic [BANK_BITS-1:0] bank;
        logic                 sel;
    } latch_t;

    latch_t st_d, st_q;
    logic   req_fall;

    always_comb begin
        st_d     = st_q;
        req_fall = !mreq_n && st_q.mreq_prev_n;
        // At the falling edge the fresh inputs are used; afterwards the capture
        eff_bank = req_fall ? bank_addr : st_q.bank;
        eff_sel  = req_fall ? mem_sel   : st_q.sel;
        st_d.mreq_prev_n = mreq_n;
        if (req_fall) begin
            st_d.bank = bank_addr;
            st_d.sel  = mem_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mreq_prev_n <= 1'b1;
            st_q.bank        <= '0;
            st_q.sel         <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dram_row_strobes.sv
module dram_row_strobes #(
    parameter int BANK_BITS = 1,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mreq_n,
    input  logic                 rfsh_n,
    input  logic [BANK_BITS-1:0] eff_bank,
    input  logic                 eff_sel,
    output logic [NBANK-1:0]     ras_n
);

    logic [NBANK-1:0] ras_d, ras_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb begin
            // Refresh bypasses the select so every bank is strobed
            ras_d[b] = mreq_n |
                       (rfsh_n & !(eff_sel && (eff_bank == BANK_BITS'(b))));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ras_q <= '1;
        else     ras_q <= ras_d;
    end

    assign ras_n = ras_q;

endmodule

// File: rtl/dram_col_timing.sv
module dram_col_timing
    import dram_strobe_pkg::*;
#(
    parameter int CAS_DLY  = 2,
    parameter int RCAS_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mreq_n,
    input  logic rfsh_n,
    output logic cas_n,
    output logic addr_col
);

    typedef struct packed {
        logic [CAS_DLY-1:0]  req_low_hist;   // 1 = memory request was low
        logic [RCAS_LEN-1:0] rfsh_high_hist; // 1 = refresh strobe was high
        col_out_t            out;
    } col_t;

    col_t st_d, st_q;
    logic cas_acc, cas_rfsh;

    always_comb begin
        st_d = st_q;
        // Access half: request held low for CAS_DLY earlier samples
        cas_acc  = !mreq_n && rfsh_n && (&st_q.req_low_hist);
        // Refresh half: short pulse after the strobe falls
        cas_rfsh = !rfsh_n && (|st_q.rfsh_high_hist);
        st_d.out.cas_n    = !(cas_acc || cas_rfsh);
        st_d.out.addr_col = !mreq_n && rfsh_n && st_q.req_low_hist[0];
        st_d.req_low_hist   = CAS_DLY'({st_q.req_low_hist, !mreq_n});
        st_d.rfsh_high_hist = RCAS_LEN'({st_q.rfsh_high_hist, rfsh_n});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.req_low_hist   <= '0;
            st_q.rfsh_high_hist <= '0;
            st_q.out.cas_n      <= 1'b1;
            st_q.out.addr_col   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cas_n    = st_q.out.cas_n;
    assign addr_col = st_q.out.addr_col;

endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
    parameter int BANK_BITS = 1,
    parameter int CAS_DLY   = 2,
    parameter int RCAS_LEN  = 2,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mreq_n,
    input  logic                 rfsh_n,
    input  logic [BANK_BITS-1:0] bank_addr,
    input  logic                 mem_sel,
    output logic [NBANK-1:0]     ras_n,
    output logic                 cas_n,
    output logic                 addr_col
);

    logic [BANK_BITS-1:0] eff_bank;
    logic                 eff_sel;

    dram_bank_latch #(.BANK_BITS(BANK_BITS)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .mreq_n    (mreq_n),
        .bank_addr (bank_addr),
        .mem_sel   (mem_sel),
        .eff_bank  (eff_bank),
        .eff_sel   (eff_sel)
    );

    dram_row_strobes #(.BANK_BITS(BANK_BITS)) u_rows (
        .clk      (clk),
        .rst      (rst),
        .mreq_n   (mreq_n),
        .rfsh_n   (rfsh_n),
        .eff_bank (eff_bank),
        .eff_sel  (eff_sel),
        .ras_n    (ras_n)
    );

    dram_col_timing #(.CAS_DLY(CAS_DLY), .RCAS_LEN(RCAS_LEN)) u_cols (
        .clk      (clk),
        .rst      (rst),
        .mreq_n   (mreq_n),
        .rfsh_n   (rfsh_n),
        .cas_n    (cas_n),
        .addr_col (addr_col)
    );

endmodule

// File: rtl/dram_strobe_ctl_chk.sv
module dram_strobe_ctl_chk #(
    parameter int NBANK = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             mreq_n,
    input logic             rfsh_n,
    input logic [NBANK-1:0] ras_n,
    input logic             cas_n,
    input logic             addr_col
);

    // R1: reset leaves all strobes inactive and the mux at row
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cas_n && (&ras_n) && !addr_col));

    // R2: at most one row strobe outside refresh
    p_one_bank_r2: assert property (@(posedge clk) disable iff (rst)
        rfsh_n |=> ($countones(~ras_n) <= 1));

    // R2: no row strobe without a memory request
    p_idle_ras_r2: assert property (@(posedge clk) disable iff (rst)
        mreq_n |=> (&ras_n));

    // R3: row strobes hold steady while an access continues
    p_latch_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && $past(!mreq_n) && rfsh_n && $past(rfsh_n)) |=> $stable(ras_n));

    // R4: refresh strobes every bank
    p_refresh_all_r4: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && !rfsh_n) |=> (ras_n == '0));

    // R5: mux stays at row during refresh
    p_row_in_refresh_r5: assert property (@(posedge clk) disable iff (rst)
        !rfsh_n |=> !addr_col);

    // R6: access column strobe only after a cycle of column address
    p_col_before_cas_r6: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && addr_col) |-> $past(addr_col));

    // R7: refresh row strobes fall with the column strobe already low
    p_cbr_order_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n[0]) && !$past(rfsh_n)) |-> !$past(cas_n));

    // R8: precharge between cycles
    p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
        (mreq_n && rfsh_n) |=> cas_n);

endmodule

bind dram_strobe_ctl dram_strobe_ctl_chk #(.NBANK(NBANK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mreq_n   (mreq_n),
    .rfsh_n   (rfsh_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .addr_col (addr_col)
);

// File: tb/dram_strobe_ctl_test.sv
module dram_strobe_ctl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mreq_n = 1'b1;
    logic       rfsh_n = 1'b1;
    logic [0:0] bank_addr = 1'b0;
    logic       mem_sel = 1'b0;
    logic [1:0] ras_n;
    logic       cas_n;
    logic       addr_col;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] ras;
        logic       cas;
        logic       col;
        string      tag;
    } exp_t;

    exp_t sb[$];

    localparam logic [1:0] NONE = 2'b11;
    localparam logic [1:0] ALL  = 2'b00;

    always #10 clk = ~clk;

    dram_strobe_ctl uut (
        .clk       (clk),
        .rst       (rst),
        .mreq_n    (mreq_n),
        .rfsh_n    (rfsh_n),
        .bank_addr (bank_addr),
        .mem_sel   (mem_sel),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .addr_col  (addr_col)
    );

    // Monitor: results of the inputs driven at the previous falling edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (ras_n !== e.ras || cas_n !== e.cas || addr_col !== e.col) begin
                    errors++;
                    $display("FAIL %s: ras_n=%b/%b cas_n=%b/%b addr_col=%b/%b (actual/expected)",
                             e.tag, ras_n, e.ras, cas_n, e.cas, addr_col, e.col);
                end
            end
        end
    end

    task automatic step(input logic r, input logic m, input logic f,
                        input logic a, input logic s,
                        input logic [1:0] er, input logic ec, input logic eco,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; mreq_n = m; rfsh_n = f; bank_addr = a; mem_sel = s;
        e.ras = er; e.cas = ec; e.col = eco; e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic [1:0] bank_ras(input logic a, input logic s);
        if (!s)      return NONE;
        else if (a)  return 2'b01;
        else         return 2'b10;
    endfunction

    // Access of n low cycles; glitch flips address and select after capture
    task automatic access(input logic a, input logic s, input int n, input bit glitch);
        logic [1:0] er;
        logic       ga, gs;
        er = bank_ras(a, s);
        ga = glitch ? ~a : a;
        gs = glitch ? ~s : s;
        step(0, 0, 1, a, s, er, 1, 0, "R2 row strobe on first low sample");
        step(0, 0, 1, ga, gs, er, 1, 1, glitch ? "R3 capture held, mux column" : "R5 mux column");
        for (int i = 2; i < n; i++)
            step(0, 0, 1, ga, gs, er, 0, 1, glitch ? "R3 capture held, cas low" : "R6 access cas low");
        step(0, 1, 1, a, s, NONE, 1, 0, "R8 precharge after access");
        step(0, 1, 1, a, s, NONE, 1, 0, "R8 idle");
    endtask

    // Refresh: strobe leads memory request by one cycle
    task automatic refresh(input logic a, input logic s);
        step(0, 1, 0, a, s, NONE, 0, 0, "R7 refresh cas leads");
        step(0, 0, 0, a, s, ALL,  0, 0, "R4 all banks, R7 cas still low");
        step(0, 0, 0, a, s, ALL,  1, 0, "R7 pulse ends, R5 row held");
        step(0, 1, 0, a, s, NONE, 1, 0, "R7 no cas while strobe low");
        step(0, 1, 1, a, s, NONE, 1, 0, "R8 idle after refresh");
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1, 1, 1, 0, 0, NONE, 1, 0, "R1 reset state");
        step(1, 1, 1, 0, 0, NONE, 1, 0, "R1 reset state");
        step(0, 1, 1, 0, 0, NONE, 1, 0, "R8 idle");

        access(1'b0, 1'b1, 3, 1'b0);   // opcode-fetch length, bank 0
        refresh(1'b0, 1'b0);            // R4 with select off
        access(1'b1, 1'b1, 4, 1'b0);   // read length, bank 1
        access(1'b0, 1'b1, 5, 1'b0);   // write length, bank 0
        access(1'b1, 1'b0, 4, 1'b0);   // R2/R6 select off: no row, cas still
        access(1'b1, 1'b1, 4, 1'b1);   // R3 glitch on bank 1
        access(1'b0, 1'b1, 3, 1'b1);   // R3 glitch on bank 0
        access(1'b0, 1'b0, 3, 1'b1);   // R3 select rising late is ignored
        refresh(1'b1, 1'b1);            // R4 with select pointing at bank 1

        // R1 reset in the middle of an access
        step(0, 0, 1, 1, 1, 2'b01, 1, 0, "R2 row strobe bank 1");
        step(0, 0, 1, 1, 1, 2'b01, 1, 1, "R5 mux column");
        step(1, 0, 1, 1, 1, NONE, 1, 0, "R1 reset mid access");
        step(0, 1, 1, 1, 1, NONE, 1, 0, "R8 idle after reset");
        access(1'b1, 1'b1, 3, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule